// File: doc/BRIEF.md
# Audio Decoder Control Register Slave

This block is the two-wire serial control port of a TV stereo and second-program audio decoder. A host writes seven control and alignment registers through a subaddressed write that steps to the next register after each data byte. It reads back a stream of two status bytes. Each status byte combines the live pilot-detection flags with one of the two expander alignment words. Every register field is driven straight out to the analog core.

A built-in alignment engine sits outside this block. While its start bit is set, it writes its results over the two alignment registers. The block also works out what each audio output carries. That choice depends on the two mode bits, the main mute and the synchronized pilot flags. Both bus lines and both pilot inputs go through a synchronizer and a majority filter before the logic uses them. The slave never stretches the clock.

Top module: `audio_ctl_i2c`

## Requirements
- R1: The slave acknowledges the 7-bit device address 1011011 when `addr_sel_i` is high and 1011010 when it is low. Any other address gets no acknowledge, and the transaction then has no effect.
- R2: A write is START, the address with R/W=0, a subaddress byte, then one or more data bytes. Each byte that is accepted is acknowledged. Each further data byte goes to the subaddress one above the previous one.
- R3: Write fields are as follows:
  - subaddress 0x04 bits 3:0 go to `st_noise_thr_o`
  - 0x05 bits 3:0 go to `sap_noise_thr_o`
  - 0x06 bit 7 is the second-program mode, bit 6 the stereo mode, bit 4 the `sap_mute_o` value and bit 3 the main mute
  - 0x07 bits 3:0 go to `in_level_o`
  - 0x08 bits 4:0 are the wideband alignment word
  - 0x09 bit 7 goes to `pilot_thr_sel_o` and bits 4:0 are the spectral alignment word
  - 0x0A bit 7 goes to `adj_run_o` and bits 2:0 go to `timing_cur_o`
- R4: Bits not named in R3 ignore writes. Bit 7 of every status byte reads 0.
- R5: A subaddress below 0x04 or above 0x0A is not acknowledged. Data bytes that would land above 0x0A are not acknowledged and write nothing. The address does not wrap.
- R6: A read has no subaddress. The slave sends status byte A, then status byte B, then A again, and so on for as long as the master acknowledges. A NACK ends the stream, and the next read starts again at A. Byte A is {0, second-program pilot, stereo pilot, wideband word[4:0]}. Byte B has the same layout with the spectral word in bits 4:0.
- R7: While `adj_run_o` is 1, the alignment words follow `eng_wide_i` and `eng_spec_i` one clock later, and host writes to them are overwritten. After the start bit is cleared, the last engine values are held and can be read back.
- R8: After reset, `sap_mute_o` is 1 and the main mute is 1. All other fields are 0 and SDA is released.
- R9: Route codes are 0 mute, 1 mono, 2 stereo channel and 3 second program. The routes are decoded from the mode bits and the pilot flags:

  | Stereo mode | Second-program mode | Pilot flag | Left | Right |
  |---|---|---|---|---|
  | 1 | 1 | second-program pilot 1 | 3 | 3 |
  | 1 | 1 | second-program pilot 0 | 0 | 0 |
  | 1 | 0 | stereo pilot 1 | 2 | 2 |
  | 1 | 0 | stereo pilot 0 | 1 | 1 |
  | 0 | 1 | second-program pilot 1 | 1 | 3 |
  | 0 | 1 | second-program pilot 0 | 1 | 0 |
  | 0 | 0 | either | 1 | 1 |

- R10: The main mute set to 1 forces both route outputs to 0 (mute) whatever the other inputs are.
- R11: A START or STOP releases SDA. A repeated START abandons the transfer in progress, including a partial data byte, and address decoding begins again.
- R12: A pulse lasting one system clock on SCL is rejected by the majority filter and does not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock, at least 20x the bus bit rate |
| rst_ni | input | 1 | asynchronous active-low reset |
| scl_i | input | 1 | bus clock line |
| sda_i | input | 1 | bus data line (wired level) |
| sda_low_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | address strap, sets address bit 0 |
| stereo_pilot_i | input | 1 | live stereo pilot detect |
| sap_pilot_i | input | 1 | live second-program pilot detect |
| eng_wide_i | input | 5 | alignment engine wideband result |
| eng_spec_i | input | 5 | alignment engine spectral result |
| st_noise_thr_o | output | 4 | stereo noise threshold code |
| sap_noise_thr_o | output | 4 | second-program noise threshold code |
| in_level_o | output | 4 | input level code |
| sap_mute_o | output | 1 | second-program output mute |
| pilot_thr_sel_o | output | 1 | pilot threshold select |
| adj_run_o | output | 1 | alignment engine run |
| timing_cur_o | output | 3 | timing current code |
| wide_align_o | output | 5 | wideband alignment word |
| spec_align_o | output | 5 | spectral alignment word |
| route_left_o | output | 2 | left output route code |
| route_right_o | output | 2 | right output route code |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a three-tap majority window. The bus runs at 40 system clocks per bit. With these settings a single-clock SCL pulse is shorter than the majority window and can be injected to show that it is rejected. The filter delay of about six clocks still leaves the slave's acknowledge and read bits settled well before the master samples them. The parameters also let the bench switch the pilot flags and see the new route within a few clocks. It can therefore cover the full routing table and the read stream with the live flags merged in.

// File: rtl/actl_pkg.sv
package actl_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [3:0] A_THR_ST  = 4'h4;
  localparam logic [3:0] A_THR_SAP = 4'h5;
  localparam logic [3:0] A_MODE    = 4'h6;
  localparam logic [3:0] A_LEVEL   = 4'h7;
  localparam logic [3:0] A_WIDE    = 4'h8;
  localparam logic [3:0] A_SPEC    = 4'h9;
  localparam logic [3:0] A_ADJ     = 4'hA;
  localparam logic [5:0] DEV_ADDR_HI = 6'b101101;

  typedef enum logic [1:0] {RT_MUTE = 2'd0, RT_MONO = 2'd1, RT_STEREO = 2'd2, RT_SAP = 2'd3} route_e;

  typedef struct packed {
    logic [3:0] st_thr;
    logic [3:0] sap_thr;
    logic       mode_sap;
    logic       mode_st;
    logic       smu;
    logic       lmu;
    logic [3:0] level;
    logic [4:0] wide;
    logic       sts;
    logic [4:0] spec;
    logic       adj;
    logic [2:0] tc;
  } ctl_fields_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int unsigned SYNC    = 2,
  parameter int unsigned TAPS    = 3,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC-1:0] sy;
  logic [TAPS-1:0] win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy  <= {SYNC{RST_VAL}};
      win <= {TAPS{RST_VAL}};
      q_o <= RST_VAL;
    end else begin
      sy  <= {sy[SYNC-2:0], d_i};
      win <= {win[TAPS-2:0], sy[SYNC-1]};
      q_o <= ($countones(win) > (TAPS / 2));
    end
  end

  a_r12_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |=> $stable(q_o));
endmodule

// File: rtl/ctl_i2c_link.sv
module ctl_i2c_link
  import actl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_lsb_i,
  input  logic [7:0]        rd_byte0_i,
  input  logic [7:0]        rd_byte1_i,
  output logic              sda_low_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam logic [7:0] SUB_LO = 8'(A_THR_ST);
  localparam logic [7:0] SUB_HI = 8'(A_ADJ);

  typedef enum logic [3:0] {S_IDLE, S_ADDR, S_ADDR_ACK, S_SUB, S_SUB_ACK,
                            S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK} link_e;

  link_e             st;
  logic              scl_q, sda_q;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx;
  logic              rw, rsel, mack;
  logic [REG_AW-1:0] ptr;
  logic              scl_rise, scl_fall, start_det, stop_det, ptr_ok;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign ptr_ok    = (ptr >= A_THR_ST) && (ptr <= A_ADJ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; cnt <= '0; sh <= '0; tx <= '0;
      rw <= 1'b0; rsel <= 1'b0; mack <= 1'b0; ptr <= '0; sda_low_o <= 1'b0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      wr_en_o <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_low_o <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_low_o <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR, S_SUB, S_WDATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == {DEV_ADDR_HI, addr_lsb_i}) begin
                  sda_low_o <= 1'b1; rw <= sh[0]; st <= S_ADDR_ACK;
                end else st <= S_IDLE;
              end else if (st == S_SUB) begin
                if (sh >= SUB_LO && sh <= SUB_HI) begin
                  sda_low_o <= 1'b1; ptr <= sh[REG_AW-1:0]; st <= S_SUB_ACK;
                end else st <= S_IDLE;
              end else begin
                if (ptr_ok) begin
                  sda_low_o <= 1'b1; wr_en_o <= 1'b1; wr_addr_o <= ptr; wr_data_o <= sh;
                end
                st <= S_WDATA_ACK;
              end
            end
          end
          S_ADDR_ACK: if (scl_fall) begin
            if (rw) begin
              tx <= {rd_byte0_i[6:0], 1'b0}; sda_low_o <= ~rd_byte0_i[7];
              rsel <= 1'b1; cnt <= 4'd1; st <= S_RDATA;
            end else begin
              sda_low_o <= 1'b0; st <= S_SUB;
            end
          end
          S_SUB_ACK: if (scl_fall) begin
            sda_low_o <= 1'b0; st <= S_WDATA;
          end
          S_WDATA_ACK: if (scl_fall) begin
            sda_low_o <= 1'b0;
            if (ptr_ok) ptr <= ptr + 1'b1;
            st <= S_WDATA;
          end
          S_RDATA: if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_low_o <= 1'b0; st <= S_RACK;
            end else begin
              sda_low_o <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_i;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rsel ? {rd_byte1_i[6:0], 1'b0} : {rd_byte0_i[6:0], 1'b0};
                sda_low_o <= rsel ? ~rd_byte1_i[7] : ~rd_byte0_i[7];
                rsel <= ~rsel; cnt <= 4'd1; st <= S_RDATA;
              end else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r11_release_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_low_o);
  a_r11_drive_while_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !scl_i);
  a_r5_write_in_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o >= A_THR_ST && wr_addr_o <= A_ADJ));
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import actl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [4:0]        eng_wide_i,
  input  logic [4:0]        eng_spec_i,
  input  logic              stp_i,
  input  logic              sapp_i,
  output ctl_fields_t       f_o,
  output logic [7:0]        rd_byte0_o,
  output logic [7:0]        rd_byte1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_o     <= '0;
      f_o.smu <= 1'b1;
      f_o.lmu <= 1'b1;
    end else begin
      if (wr_en_i) begin
        unique case (wr_addr_i)
          A_THR_ST:  f_o.st_thr  <= wr_data_i[3:0];
          A_THR_SAP: f_o.sap_thr <= wr_data_i[3:0];
          A_MODE: begin
            f_o.mode_sap <= wr_data_i[7];
            f_o.mode_st  <= wr_data_i[6];
            f_o.smu      <= wr_data_i[4];
            f_o.lmu      <= wr_data_i[3];
          end
          A_LEVEL: f_o.level <= wr_data_i[3:0];
          A_WIDE:  f_o.wide  <= wr_data_i[4:0];
          A_SPEC: begin
            f_o.sts  <= wr_data_i[7];
            f_o.spec <= wr_data_i[4:0];
          end
          A_ADJ: begin
            f_o.adj <= wr_data_i[7];
            f_o.tc  <= wr_data_i[2:0];
          end
          default: ;
        endcase
      end
      // engine results take precedence over host writes
      if (f_o.adj) begin
        f_o.wide <= eng_wide_i;
        f_o.spec <= eng_spec_i;
      end
    end
  end

  assign rd_byte0_o = {1'b0, sapp_i, stp_i, f_o.wide};
  assign rd_byte1_o = {1'b0, sapp_i, stp_i, f_o.spec};

  a_r7_engine_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_o.adj |=> f_o.wide == $past(eng_wide_i));
  a_r7_engine_spec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_o.adj |=> f_o.spec == $past(eng_spec_i));
endmodule

// File: rtl/route_sel.sv
module route_sel
  import actl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mode_st_i,
  input  logic   mode_sap_i,
  input  logic   lmu_i,
  input  logic   stp_i,
  input  logic   sapp_i,
  output route_e route_l_o,
  output route_e route_r_o
);
  always_comb begin
    route_l_o = RT_MONO;
    route_r_o = RT_MONO;
    unique case ({mode_st_i, mode_sap_i})
      2'b11: begin
        route_l_o = sapp_i ? RT_SAP : RT_MUTE;
        route_r_o = sapp_i ? RT_SAP : RT_MUTE;
      end
      2'b10: begin
        route_l_o = stp_i ? RT_STEREO : RT_MONO;
        route_r_o = stp_i ? RT_STEREO : RT_MONO;
      end
      2'b01: route_r_o = sapp_i ? RT_SAP : RT_MUTE;
      default: ;
    endcase
    if (lmu_i) begin
      route_l_o = RT_MUTE;
      route_r_o = RT_MUTE;
    end
  end

  a_r10_main_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmu_i |-> (route_l_o == RT_MUTE && route_r_o == RT_MUTE));
  a_r9_sap_needs_pilot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_r_o == RT_SAP) |-> (sapp_i && mode_sap_i));
  a_r9_stereo_needs_pilot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_l_o == RT_STEREO) |-> (stp_i && mode_st_i && !mode_sap_i));
endmodule

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c
  import actl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_TAPS   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_low_o,
  input  logic       addr_sel_i,
  input  logic       stereo_pilot_i,
  input  logic       sap_pilot_i,
  input  logic [4:0] eng_wide_i,
  input  logic [4:0] eng_spec_i,
  output logic [3:0] st_noise_thr_o,
  output logic [3:0] sap_noise_thr_o,
  output logic [3:0] in_level_o,
  output logic       sap_mute_o,
  output logic       pilot_thr_sel_o,
  output logic       adj_run_o,
  output logic [2:0] timing_cur_o,
  output logic [4:0] wide_align_o,
  output logic [4:0] spec_align_o,
  output logic [1:0] route_left_o,
  output logic [1:0] route_right_o
);
  localparam int unsigned N_LINES = 4;

  logic [N_LINES-1:0] raw, clean;
  assign raw = {stereo_pilot_i, sap_pilot_i, sda_i, scl_i};

  // bus lines idle high, pilot flags idle low
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    line_filter #(.SYNC(SYNC_STAGES), .TAPS(FILT_TAPS), .RST_VAL(g < 2)) i_flt (
      .clk_i, .rst_ni, .d_i(raw[g]), .q_o(clean[g])
    );
  end

  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;
  logic [7:0]        wr_data, rd0, rd1;
  ctl_fields_t       f;
  route_e            rl, rr;

  ctl_i2c_link i_link (
    .clk_i, .rst_ni, .scl_i(clean[0]), .sda_i(clean[1]), .addr_lsb_i(addr_sel_i),
    .rd_byte0_i(rd0), .rd_byte1_i(rd1), .sda_low_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  ctl_regbank i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .eng_wide_i, .eng_spec_i, .stp_i(clean[3]), .sapp_i(clean[2]),
    .f_o(f), .rd_byte0_o(rd0), .rd_byte1_o(rd1)
  );

  route_sel i_route (
    .clk_i, .rst_ni, .mode_st_i(f.mode_st), .mode_sap_i(f.mode_sap), .lmu_i(f.lmu),
    .stp_i(clean[3]), .sapp_i(clean[2]), .route_l_o(rl), .route_r_o(rr)
  );

  assign st_noise_thr_o  = f.st_thr;
  assign sap_noise_thr_o = f.sap_thr;
  assign in_level_o      = f.level;
  assign sap_mute_o      = f.smu;
  assign pilot_thr_sel_o = f.sts;
  assign adj_run_o       = f.adj;
  assign timing_cur_o    = f.tc;
  assign wide_align_o    = f.wide;
  assign spec_align_o    = f.spec;
  assign route_left_o    = rl;
  assign route_right_o   = rr;
endmodule

// File: tb/test_audio_ctl_i2c.sv
module test_audio_ctl_i2c;
  localparam int Q = 10;
  localparam logic [6:0] DEV_HI = 7'h5B;
  localparam logic [6:0] DEV_LO = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_low, sda_line;
  logic addr_sel = 1'b1, stp = 1'b0, sapp = 1'b0;
  logic [4:0] ew = '0, es = '0;
  logic [3:0] st_thr, sap_thr, lvl;
  logic sap_mute, sts, adj;
  logic [2:0] tc;
  logic [4:0] wide, spec;
  logic [1:0] rl, rr;
  assign sda_line = m_sda & ~sda_low;

  audio_ctl_i2c i_audio_ctl_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_low_o(sda_low),
    .addr_sel_i(addr_sel), .stereo_pilot_i(stp), .sap_pilot_i(sapp),
    .eng_wide_i(ew), .eng_spec_i(es), .st_noise_thr_o(st_thr), .sap_noise_thr_o(sap_thr),
    .in_level_o(lvl), .sap_mute_o(sap_mute), .pilot_thr_sel_o(sts), .adj_run_o(adj),
    .timing_cur_o(tc), .wide_align_o(wide), .spec_align_o(spec),
    .route_left_o(rl), .route_right_o(rr)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_w(input logic b, input bit glitch);
    m_sda = b; qwait(Q); m_scl = 1'b1;
    if (glitch) begin
      qwait(Q); m_scl = 1'b0; qwait(1); m_scl = 1'b1; qwait(Q - 1);
    end else qwait(2 * Q);
    m_scl = 1'b0; qwait(Q);
  endtask

  task automatic bit_r(output logic r);
    m_sda = 1'b1; qwait(Q); m_scl = 1'b1; qwait(Q); r = sda_line;
    qwait(Q); m_scl = 1'b0; qwait(Q);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; qwait(Q); m_scl = 1'b1; qwait(Q); m_sda = 1'b0; qwait(Q); m_scl = 1'b0; qwait(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; qwait(Q); m_scl = 1'b1; qwait(Q); m_sda = 1'b1; qwait(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_w(b[i], glitch);
    bit_r(r);
    ack = ~r;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_r(r);
      d[i] = r;
    end
    bit_w(~ack, 1'b0);
  endtask

  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] sub,
                          input logic [7:0] d[$], input bit glitch, output int acks);
    bit a;
    acks = 0;
    i2c_start;
    send_byte({dev, 1'b0}, 1'b0, a); acks += int'(a);
    send_byte(sub, 1'b0, a); acks += int'(a);
    foreach (d[i]) begin
      send_byte(d[i], glitch, a); acks += int'(a);
    end
    i2c_stop;
    qwait(4);
  endtask

  // driver pushes into exp_q beforehand; this monitor pops per received byte
  task automatic rd_stream(input int n, input string req);
    bit a;
    logic [7:0] d;
    i2c_start;
    send_byte({DEV_HI, 1'b1}, 1'b0, a);
    check({req, " read address ack"}, int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check({req, " status byte"}, int'(d), int'(exp_q.pop_front()));
    end
    i2c_stop;
    qwait(4);
  endtask

  task automatic set_mode(input logic [7:0] v);
    int acks;
    wr_burst(DEV_HI, 8'h06, '{v}, 1'b0, acks);
    check("R9 mode write acks", acks, 3);
  endtask

  task automatic route_chk(input string req, input int l, input int r);
    qwait(10);
    check({req, " left"}, int'(rl), l);
    check({req, " right"}, int'(rr), r);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int acks;
    bit a;
    logic r;
    qwait(5);
    rst_n = 1'b1;
    qwait(5);
    // R8 reset state
    check("R8 sap mute", int'(sap_mute), 1);
    check("R8 left muted", int'(rl), 0);
    check("R8 right muted", int'(rr), 0);
    check("R8 thr", int'(st_thr), 0);
    check("R8 adj", int'(adj), 0);
    check("R8 sda released", int'(sda_low), 0);

    // R2 R3 R4 full burst from 0x04
    wr_burst(DEV_HI, 8'h04, '{8'hFA, 8'h03, 8'h67, 8'h0C, 8'hF2, 8'h95, 8'h05}, 1'b0, acks);
    check("R2 burst acks", acks, 9);
    check("R3 R4 stereo thr", int'(st_thr), 'hA);
    check("R3 sap thr", int'(sap_thr), 3);
    check("R3 sap mute cleared", int'(sap_mute), 0);
    check("R3 level", int'(lvl), 'hC);
    check("R3 R4 wide", int'(wide), 'h12);
    check("R3 sts", int'(sts), 1);
    check("R3 spec", int'(spec), 'h15);
    check("R3 adj", int'(adj), 0);
    check("R3 tc", int'(tc), 5);

    // R9 stereo mode, pilot off then on
    route_chk("R9 stereo no pilot", 1, 1);
    stp = 1'b1;
    route_chk("R9 stereo pilot", 2, 2);

    // R6 read stream alternates, R4 bit7 zero
    exp_q.push_back(8'h32); exp_q.push_back(8'h35); exp_q.push_back(8'h32);
    rd_stream(3, "R6 R4");
    sapp = 1'b1; qwait(10);
    exp_q.push_back(8'h72);
    rd_stream(1, "R6 restart");

    // R1 strap
    addr_sel = 1'b0; qwait(4);
    wr_burst(DEV_HI, 8'h04, '{8'h01}, 1'b0, acks);
    check("R1 strap low, 5B nacked", acks, 0);
    check("R1 no write", int'(st_thr), 'hA);
    wr_burst(DEV_LO, 8'h07, '{8'h0E}, 1'b0, acks);
    check("R1 strap low, 5A acked", acks, 3);
    check("R1 level", int'(lvl), 'hE);
    addr_sel = 1'b1; qwait(4);
    wr_burst(DEV_LO, 8'h07, '{8'h02}, 1'b0, acks);
    check("R1 strap high, 5A nacked", acks, 0);
    check("R1 level held", int'(lvl), 'hE);

    // R5 out of map
    wr_burst(DEV_HI, 8'h03, '{8'h01}, 1'b0, acks);
    check("R5 sub 03 nacked", acks, 1);
    wr_burst(DEV_HI, 8'h0B, '{8'h01}, 1'b0, acks);
    check("R5 sub 0B nacked", acks, 1);
    wr_burst(DEV_HI, 8'h0A, '{8'h03, 8'hFF}, 1'b0, acks);
    check("R5 past end nacked", acks, 3);
    check("R5 tc", int'(tc), 3);
    check("R5 no wrap", int'(st_thr), 'hA);
    check("R5 adj untouched", int'(adj), 0);

    // R7 alignment engine
    ew = 5'h07; es = 5'h19;
    wr_burst(DEV_HI, 8'h0A, '{8'h80}, 1'b0, acks);
    check("R7 adj on", int'(adj), 1);
    check("R7 wide follow", int'(wide), 'h07);
    check("R7 spec follow", int'(spec), 'h19);
    ew = 5'h0B; es = 5'h1C; qwait(5);
    check("R7 wide track", int'(wide), 'h0B);
    wr_burst(DEV_HI, 8'h08, '{8'h01}, 1'b0, acks);
    check("R7 host write overridden", int'(wide), 'h0B);
    wr_burst(DEV_HI, 8'h0A, '{8'h00}, 1'b0, acks);
    ew = 5'h01; es = 5'h02; qwait(5);
    check("R7 wide held", int'(wide), 'h0B);
    check("R7 spec held", int'(spec), 'h1C);
    exp_q.push_back(8'h6B); exp_q.push_back(8'h7C);
    rd_stream(2, "R7 readback");

    // R9 routing table, R10 main mute
    set_mode(8'hC0);
    route_chk("R9 both sap pilot", 3, 3);
    sapp = 1'b0;
    route_chk("R9 both sap no pilot", 0, 0);
    set_mode(8'h80);
    route_chk("R9 mono+sap no pilot", 1, 0);
    sapp = 1'b1;
    route_chk("R9 mono+sap pilot", 1, 3);
    set_mode(8'h00);
    route_chk("R9 mono", 1, 1);
    set_mode(8'hC8);
    route_chk("R10 mute sap mode", 0, 0);
    set_mode(8'h48);
    route_chk("R10 mute stereo mode", 0, 0);
    set_mode(8'h10);
    check("R3 smu set", int'(sap_mute), 1);

    // R11 repeated start
    i2c_start;
    send_byte({DEV_HI, 1'b0}, 1'b0, a);
    send_byte(8'h04, 1'b0, a);
    i2c_start;
    check("R11 sda released at start", int'(sda_low), 0);
    send_byte({DEV_HI, 1'b0}, 1'b0, a);
    check("R11 address after restart", int'(a), 1);
    send_byte(8'h07, 1'b0, a);
    send_byte(8'h09, 1'b0, a);
    i2c_stop; qwait(4);
    check("R11 restart write", int'(lvl), 9);
    check("R11 first target untouched", int'(st_thr), 'hA);
    i2c_start;
    send_byte({DEV_HI, 1'b0}, 1'b0, a);
    send_byte(8'h05, 1'b0, a);
    for (int i = 0; i < 4; i++) bit_w(1'b1, 1'b0);
    i2c_start;
    send_byte({DEV_HI, 1'b0}, 1'b0, a);
    send_byte(8'h07, 1'b0, a);
    send_byte(8'h0D, 1'b0, a);
    i2c_stop; qwait(4);
    check("R11 partial byte dropped", int'(sap_thr), 3);
    check("R11 write after abort", int'(lvl), 'hD);
    check("R11 sda released at stop", int'(sda_low), 0);

    // R12 single-clock SCL glitches in every data bit
    wr_burst(DEV_HI, 8'h05, '{8'h0C}, 1'b1, acks);
    check("R12 glitch acks", acks, 3);
    check("R12 glitch data", int'(sap_thr), 'hC);
    bit_r(r);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule